// File: doc/BRIEF.md
# BCH Correction Applier

This block runs after a per-sector BCH decoder has finished on one page. It reads the decoder's error report through a synchronous report port. The report holds one status byte per sector, the error locations and the error values. The block uses the report to repair the page in place, working on a byte-wide page buffer and a 32-bit spare-area word store. Each correctable error is XORed into one of three places: a data byte of the page, one of the three ECC-protected leading spare bytes, or a stored parity byte.

A start pulse begins a pass with a fixed strength and page size. The block visits the sectors in order and counts the corrected errors. It stops early if any sector is uncorrectable. At the end it pulses `done_o` and presents the total count and the fail flag at the same time. The strength, page-size and spare-size inputs must stay stable for the whole pass.

Top module: `ecc_fix_top`

## Requirements
- R1: For sector s, the status byte is byte lane s mod 4 (lane 0 = bits [7:0]) of status word s/4. Its bits [1:0] decode as 0 = clean, 1 = correctable, 2 or 3 = uncorrectable.
- R2: For a correctable sector, the error count is status bits [6:2]. A count above 24 is clamped to 24. The counts of all corrected sectors are summed into `corr_cnt_o`.
- R3: Error e is located by word e/2 of the location list: bits [10:0] when e is even, bits [26:16] when e is odd. Its value is byte lane e mod 4 of word e/4 of the value list.
- R4: A location below the sector size targets page byte (sector × sector size + location). That byte is read, then written one cycle later at the same address with the value XORed in.
- R5: A location from the sector size up to the sector size + 2 targets spare byte (location − sector size).
- R6: A location at or above (sector size + padding − parity length) is a parity byte. It targets spare byte (spare size − parity length × sectors per page) + parity length × sector + (location − (sector size + padding − parity length)).
- R7: A location between the sector size + 3 and the first parity location causes no memory access. It still counts toward the sum.
- R8: `strength_i` selects the code: 0 = 8-bit strength (512-byte sectors, 15 parity bytes, 32 padding), 1 = 12-bit strength (512, 23, 32), and 2 or 3 = 24-bit strength (1024, 45, 64). `page_size_i` selects the page: 0 = 2 KiB, 1 = 4 KiB, 2 or 3 = 8 KiB.
- R9: The pass scans max(1, sectors per page / 4) status words and decodes all four slots of every scanned word.
- R10: An uncorrectable sector ends the pass at once. It sets `fail_o`, and no later sector is touched.
- R11: `done_o` is a one-cycle pulse. `corr_cnt_o` and `fail_o` are valid with it. A start pulse during a pass has no effect.
- R12: Spare updates are read-modify-write on the word (byte address / 4). Only lane (byte address mod 4) changes, and the other three lanes keep their values.
- R13: After reset, `done_o`, `fail_o`, `corr_cnt_o` and every port enable are 0. At most one of the report, page and spare enables is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a correction pass |
| strength_i | input | 2 | Code strength select |
| page_size_i | input | 2 | Page size select |
| spare_size_i | input | SPARE_AW | Spare area size in bytes |
| rep_re_o | output | 1 | Report read enable |
| rep_sel_o | output | 2 | Report list: 0 status, 1 locations, 2 values |
| rep_sector_o | output | SEC_W | Sector whose location or value list is read |
| rep_word_o | output | RW_W | Word index within the selected list |
| rep_rdata_i | input | 32 | Report word, valid the cycle after the read |
| pg_re_o | output | 1 | Page buffer read enable |
| pg_we_o | output | 1 | Page buffer write enable |
| pg_addr_o | output | PAGE_AW | Page byte address |
| pg_wdata_o | output | 8 | Page write data |
| pg_rdata_i | input | 8 | Page read data, one cycle latency |
| sp_re_o | output | 1 | Spare store read enable |
| sp_we_o | output | 1 | Spare store write enable |
| sp_addr_o | output | SPARE_AW-2 | Spare word address |
| sp_wdata_o | output | 32 | Spare write data |
| sp_rdata_i | input | 32 | Spare read data, one cycle latency |
| done_o | output | 1 | Pass complete pulse |
| fail_o | output | 1 | Page uncorrectable |
| corr_cnt_o | output | CNT_W | Total corrected errors |

## Verification
Some rules are checked by the assertions on every cycle. `done_o` must be a single-cycle pulse. Every page or spare write must follow a read of the same address in the previous cycle. Only one memory or report enable may be active at a time, and no write may happen while the fail flag is raised. The bench scenarios cover what depends on the data itself: where each location lands for each strength and page size, the parity offset arithmetic, lane isolation, the clamp at 24, the skipped padding gap, the early stop on an uncorrectable sector, and the summed count.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int unsigned LOC_W  = 11;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {DST_DATA, DST_PROT, DST_PAR, DST_NONE} dest_e;
  typedef enum logic [1:0] {REP_STATUS = 2'd0, REP_LOC = 2'd1, REP_VAL = 2'd2} rep_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ST_RD, S_ST_CAP, S_LOC_RD, S_LOC_CAP,
    S_VAL_RD, S_VAL_CAP, S_MEM_RD, S_MEM_WR, S_DONE
  } state_e;

  typedef struct packed {
    logic [10:0] ssz;
    logic [6:0]  pad;
    logic [5:0]  plen;
    logic [4:0]  nsec;
    logic [2:0]  nwords;
  } geom_t;
endpackage

// File: rtl/ecc_fix_geom.sv
module ecc_fix_geom
  import ecc_fix_pkg::*;
(
  input  logic [1:0] strength_i,
  input  logic [1:0] page_size_i,
  output geom_t      geom_o
);
  logic [3:0] page_exp, sec_exp, sh;

  always_comb begin
    geom_o = '0;
    case (strength_i)
      2'd0:    begin geom_o.ssz = 11'd512;  geom_o.pad = 7'd32; geom_o.plen = 6'd15; sec_exp = 4'd9;  end
      2'd1:    begin geom_o.ssz = 11'd512;  geom_o.pad = 7'd32; geom_o.plen = 6'd23; sec_exp = 4'd9;  end
      default: begin geom_o.ssz = 11'd1024; geom_o.pad = 7'd64; geom_o.plen = 6'd45; sec_exp = 4'd10; end
    endcase
    page_exp = (page_size_i == 2'd3) ? 4'd13 : 4'd11 + {2'b00, page_size_i};
    sh = page_exp - sec_exp;
    geom_o.nsec   = 5'd1 << sh;
    geom_o.nwords = (geom_o.nsec < 5'd4) ? 3'd1 : geom_o.nsec[4:2];
  end
endmodule

// File: rtl/ecc_fix_route.sv
module ecc_fix_route
  import ecc_fix_pkg::*;
#(
  parameter int unsigned PAGE_AW  = 13,
  parameter int unsigned SPARE_AW = 9,
  parameter int unsigned SEC_W    = 4
) (
  input  logic [10:0]         ssz_i,
  input  logic [6:0]          pad_i,
  input  logic [5:0]          plen_i,
  input  logic [4:0]          nsec_i,
  input  logic [LOC_W-1:0]    loc_i,
  input  logic [SEC_W-1:0]    sec_i,
  input  logic [SPARE_AW-1:0] spare_size_i,
  output dest_e               dest_o,
  output logic [PAGE_AW-1:0]  pg_addr_o,
  output logic [SPARE_AW-1:0] sp_byte_o
);
  localparam int unsigned CW = ((PAGE_AW > SPARE_AW) ? PAGE_AW : SPARE_AW) + 4;

  logic [CW-1:0] ssz, pad, plen, nsec, loc, sec, spsz, par_start;

  assign ssz  = CW'(ssz_i);
  assign pad  = CW'(pad_i);
  assign plen = CW'(plen_i);
  assign nsec = CW'(nsec_i);
  assign loc  = CW'(loc_i);
  assign sec  = CW'(sec_i);
  assign spsz = CW'(spare_size_i);
  assign par_start = ssz + pad - plen;

  always_comb begin
    if (loc < ssz)                  dest_o = DST_DATA;
    else if (loc < ssz + CW'(3))    dest_o = DST_PROT;
    else if (loc < par_start)       dest_o = DST_NONE;
    else                            dest_o = DST_PAR;
  end

  assign pg_addr_o = PAGE_AW'(sec * ssz + loc);
  assign sp_byte_o = (dest_o == DST_PROT)
                   ? SPARE_AW'(loc - ssz)
                   : SPARE_AW'(spsz - plen * nsec + plen * sec + (loc - par_start));
endmodule

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
#(
  parameter int unsigned PAGE_AW  = 13,
  parameter int unsigned SPARE_AW = 9,
  parameter int unsigned SEC_W    = 4,
  parameter int unsigned MAX_ERR  = 24,
  parameter int unsigned CNT_W    = 9,
  localparam int unsigned ERR_W   = $clog2(MAX_ERR + 1),
  localparam int unsigned RW_W    = $clog2(MAX_ERR / 2),
  localparam int unsigned SP_WAW  = SPARE_AW - 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          nwords_i,
  output logic                rep_re_o,
  output logic [1:0]          rep_sel_o,
  output logic [SEC_W-1:0]    rep_sector_o,
  output logic [RW_W-1:0]     rep_word_o,
  input  logic [WORD_W-1:0]   rep_rdata_i,
  output logic [LOC_W-1:0]    loc_o,
  output logic [SEC_W-1:0]    sec_o,
  input  dest_e               dest_i,
  input  logic [PAGE_AW-1:0]  rt_pg_addr_i,
  input  logic [SPARE_AW-1:0] rt_sp_byte_i,
  output logic                pg_re_o,
  output logic                pg_we_o,
  output logic [PAGE_AW-1:0]  pg_addr_o,
  output logic [7:0]          pg_wdata_o,
  input  logic [7:0]          pg_rdata_i,
  output logic                sp_re_o,
  output logic                sp_we_o,
  output logic [SP_WAW-1:0]   sp_addr_o,
  output logic [WORD_W-1:0]   sp_wdata_o,
  input  logic [WORD_W-1:0]   sp_rdata_i,
  output logic                done_o,
  output logic                fail_o,
  output logic [CNT_W-1:0]    corr_cnt_o
);
  state_e            state_q;
  logic [SEC_W-1:0]  sec_q;
  logic [ERR_W-1:0]  err_q, nerr_q;
  logic [LOC_W-1:0]  loc_q;
  logic [7:0]        val_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              fail_q;

  logic [SEC_W:0]    last_sec;
  logic              sec_last, err_last;
  logic [1:0]        stat_code;
  logic [4:0]        stat_cnt;
  logic [ERR_W-1:0]  nerr_clamp;
  logic              to_page, to_spare;

  assign last_sec  = (SEC_W+1)'({nwords_i, 2'b00}) - 1'b1;
  assign sec_last  = ({1'b0, sec_q} == last_sec);
  assign err_last  = (err_q == nerr_q - 1'b1);
  assign stat_code = rep_rdata_i[{sec_q[1:0], 3'b000} +: 2];
  assign stat_cnt  = rep_rdata_i[{sec_q[1:0], 3'b010} +: 5];
  assign nerr_clamp = (ERR_W'(stat_cnt) > ERR_W'(MAX_ERR)) ? ERR_W'(MAX_ERR) : ERR_W'(stat_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sec_q   <= '0;
      err_q   <= '0;
      nerr_q  <= '0;
      loc_q   <= '0;
      val_q   <= '0;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          cnt_q   <= '0;
          fail_q  <= 1'b0;
          sec_q   <= '0;
          state_q <= S_ST_RD;
        end
        S_ST_RD: state_q <= S_ST_CAP;
        S_ST_CAP: begin
          if (stat_code[1]) begin
            fail_q  <= 1'b1;
            state_q <= S_DONE;
          end else if (stat_code[0] && nerr_clamp != '0) begin
            nerr_q  <= nerr_clamp;
            err_q   <= '0;
            cnt_q   <= cnt_q + CNT_W'(nerr_clamp);
            state_q <= S_LOC_RD;
          end else if (sec_last) begin
            state_q <= S_DONE;
          end else begin
            sec_q   <= sec_q + 1'b1;
            state_q <= S_ST_RD;
          end
        end
        S_LOC_RD: state_q <= S_LOC_CAP;
        S_LOC_CAP: begin
          loc_q   <= err_q[0] ? rep_rdata_i[16 +: LOC_W] : rep_rdata_i[0 +: LOC_W];
          state_q <= S_VAL_RD;
        end
        S_VAL_RD: state_q <= S_VAL_CAP;
        S_VAL_CAP: begin
          val_q   <= rep_rdata_i[{err_q[1:0], 3'b000} +: 8];
          state_q <= S_MEM_RD;
        end
        S_MEM_RD, S_MEM_WR: begin
          if (state_q == S_MEM_RD && dest_i != DST_NONE) begin
            state_q <= S_MEM_WR;
          end else if (!err_last) begin
            err_q   <= err_q + 1'b1;
            state_q <= S_LOC_RD;
          end else if (sec_last) begin
            state_q <= S_DONE;
          end else begin
            sec_q   <= sec_q + 1'b1;
            state_q <= S_ST_RD;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rep_re_o   = 1'b0;
    rep_sel_o  = REP_STATUS;
    rep_word_o = '0;
    case (state_q)
      S_ST_RD:  begin rep_re_o = 1'b1; rep_sel_o = REP_STATUS; rep_word_o = RW_W'(sec_q >> 2); end
      S_LOC_RD: begin rep_re_o = 1'b1; rep_sel_o = REP_LOC;    rep_word_o = RW_W'(err_q >> 1); end
      S_VAL_RD: begin rep_re_o = 1'b1; rep_sel_o = REP_VAL;    rep_word_o = RW_W'(err_q >> 2); end
      default: ;
    endcase
  end

  assign rep_sector_o = sec_q;
  assign loc_o = loc_q;
  assign sec_o = sec_q;

  assign to_page  = (dest_i == DST_DATA);
  assign to_spare = (dest_i == DST_PROT) || (dest_i == DST_PAR);

  assign pg_re_o    = (state_q == S_MEM_RD) && to_page;
  assign pg_we_o    = (state_q == S_MEM_WR) && to_page;
  assign pg_addr_o  = rt_pg_addr_i;
  assign pg_wdata_o = pg_rdata_i ^ val_q;

  assign sp_re_o    = (state_q == S_MEM_RD) && to_spare;
  assign sp_we_o    = (state_q == S_MEM_WR) && to_spare;
  assign sp_addr_o  = rt_sp_byte_i[SPARE_AW-1:2];
  assign sp_wdata_o = sp_rdata_i ^ (WORD_W'(val_q) << {rt_sp_byte_i[1:0], 3'b000});

  assign done_o     = (state_q == S_DONE);
  assign fail_o     = fail_q;
  assign corr_cnt_o = cnt_q;
endmodule

// File: rtl/ecc_fix_top.sv
module ecc_fix_top
  import ecc_fix_pkg::*;
#(
  parameter int unsigned PAGE_AW  = 13,
  parameter int unsigned SPARE_AW = 9,
  parameter int unsigned SEC_W    = 4,
  parameter int unsigned MAX_ERR  = 24,
  parameter int unsigned CNT_W    = 9,
  localparam int unsigned RW_W    = $clog2(MAX_ERR / 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [1:0]            strength_i,
  input  logic [1:0]            page_size_i,
  input  logic [SPARE_AW-1:0]   spare_size_i,
  output logic                  rep_re_o,
  output logic [1:0]            rep_sel_o,
  output logic [SEC_W-1:0]      rep_sector_o,
  output logic [RW_W-1:0]       rep_word_o,
  input  logic [31:0]           rep_rdata_i,
  output logic                  pg_re_o,
  output logic                  pg_we_o,
  output logic [PAGE_AW-1:0]    pg_addr_o,
  output logic [7:0]            pg_wdata_o,
  input  logic [7:0]            pg_rdata_i,
  output logic                  sp_re_o,
  output logic                  sp_we_o,
  output logic [SPARE_AW-3:0]   sp_addr_o,
  output logic [31:0]           sp_wdata_o,
  input  logic [31:0]           sp_rdata_i,
  output logic                  done_o,
  output logic                  fail_o,
  output logic [CNT_W-1:0]      corr_cnt_o
);
  geom_t               geom;
  dest_e               dest;
  logic [LOC_W-1:0]    loc;
  logic [SEC_W-1:0]    sec;
  logic [PAGE_AW-1:0]  rt_pg_addr;
  logic [SPARE_AW-1:0] rt_sp_byte;

  ecc_fix_geom u_geom (
    .strength_i (strength_i),
    .page_size_i(page_size_i),
    .geom_o     (geom)
  );

  ecc_fix_route #(
    .PAGE_AW(PAGE_AW), .SPARE_AW(SPARE_AW), .SEC_W(SEC_W)
  ) u_route (
    .ssz_i       (geom.ssz),
    .pad_i       (geom.pad),
    .plen_i      (geom.plen),
    .nsec_i      (geom.nsec),
    .loc_i       (loc),
    .sec_i       (sec),
    .spare_size_i(spare_size_i),
    .dest_o      (dest),
    .pg_addr_o   (rt_pg_addr),
    .sp_byte_o   (rt_sp_byte)
  );

  ecc_fix_ctrl #(
    .PAGE_AW(PAGE_AW), .SPARE_AW(SPARE_AW), .SEC_W(SEC_W),
    .MAX_ERR(MAX_ERR), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .nwords_i    (geom.nwords),
    .rep_re_o    (rep_re_o),
    .rep_sel_o   (rep_sel_o),
    .rep_sector_o(rep_sector_o),
    .rep_word_o  (rep_word_o),
    .rep_rdata_i (rep_rdata_i),
    .loc_o       (loc),
    .sec_o       (sec),
    .dest_i      (dest),
    .rt_pg_addr_i(rt_pg_addr),
    .rt_sp_byte_i(rt_sp_byte),
    .pg_re_o     (pg_re_o),
    .pg_we_o     (pg_we_o),
    .pg_addr_o   (pg_addr_o),
    .pg_wdata_o  (pg_wdata_o),
    .pg_rdata_i  (pg_rdata_i),
    .sp_re_o     (sp_re_o),
    .sp_we_o     (sp_we_o),
    .sp_addr_o   (sp_addr_o),
    .sp_wdata_o  (sp_wdata_o),
    .sp_rdata_i  (sp_rdata_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .corr_cnt_o  (corr_cnt_o)
  );
endmodule

// File: rtl/ecc_fix_chk.sv
module ecc_fix_chk #(
  parameter int unsigned PAGE_AW = 13,
  parameter int unsigned SP_WAW  = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               done_o,
  input logic               fail_o,
  input logic               rep_re_o,
  input logic               pg_re_o,
  input logic               pg_we_o,
  input logic [PAGE_AW-1:0] pg_addr_o,
  input logic               sp_re_o,
  input logic               sp_we_o,
  input logic [SP_WAW-1:0]  sp_addr_o
);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_page_rmw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_o |-> ($past(pg_re_o) && $past(pg_addr_o) == pg_addr_o));

  assert_spare_rmw_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> ($past(sp_re_o) && $past(sp_addr_o) == sp_addr_o));

  assert_one_port_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rep_re_o, pg_re_o, pg_we_o, sp_re_o, sp_we_o}));

  assert_fail_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!pg_we_o && !sp_we_o));
endmodule

bind ecc_fix_top ecc_fix_chk #(.PAGE_AW(PAGE_AW), .SP_WAW(SPARE_AW - 2)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .fail_o   (fail_o),
  .rep_re_o (rep_re_o),
  .pg_re_o  (pg_re_o),
  .pg_we_o  (pg_we_o),
  .pg_addr_o(pg_addr_o),
  .sp_re_o  (sp_re_o),
  .sp_we_o  (sp_we_o),
  .sp_addr_o(sp_addr_o)
);

// File: tb/ecc_fix_top_tb.sv
module ecc_fix_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  strength_i = '0;
  logic [1:0]  page_size_i = '0;
  logic [8:0]  spare_size_i = 9'd64;
  logic        rep_re_o;
  logic [1:0]  rep_sel_o;
  logic [3:0]  rep_sector_o, rep_word_o;
  logic [31:0] rep_rdata_i;
  logic        pg_re_o, pg_we_o;
  logic [12:0] pg_addr_o;
  logic [7:0]  pg_wdata_o, pg_rdata_i;
  logic        sp_re_o, sp_we_o;
  logic [6:0]  sp_addr_o;
  logic [31:0] sp_wdata_o, sp_rdata_i;
  logic        done_o, fail_o;
  logic [8:0]  corr_cnt_o;

  int n_run = 0, n_fail = 0;
  logic clr_mem = 1'b0;

  always #10 clk_i = ~clk_i;

  ecc_fix_top u_dut (.*);

  // report lists
  logic [31:0] st_mem [4];
  logic [31:0] loc_mem [16][12];
  logic [31:0] val_mem [16][6];

  always @(posedge clk_i)
    if (rep_re_o)
      case (rep_sel_o)
        2'd0:    rep_rdata_i <= st_mem[rep_word_o[1:0]];
        2'd1:    rep_rdata_i <= loc_mem[rep_sector_o][rep_word_o];
        default: rep_rdata_i <= val_mem[rep_sector_o][rep_word_o[2:0]];
      endcase

  // sparse page model: pattern plus small overwrite table
  logic [12:0] ov_addr [32];
  logic [7:0]  ov_data [32];
  logic        ov_vld  [32];
  logic [31:0] sp_mem  [128];

  function automatic logic [7:0] pg_init(input int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] sp_init(input int b);
    return 8'(b ^ 8'hA5);
  endfunction

  function automatic logic [7:0] pg_peek(input int a);
    logic [7:0] d = pg_init(a);
    for (int i = 0; i < 32; i++) if (ov_vld[i] && ov_addr[i] == 13'(a)) d = ov_data[i];
    return d;
  endfunction

  function automatic logic [7:0] sp_peek(input int b);
    return sp_mem[b >> 2][(b % 4) * 8 +: 8];
  endfunction

  always @(posedge clk_i) begin
    if (clr_mem) begin
      for (int i = 0; i < 32; i++) ov_vld[i] = 1'b0;
      for (int i = 0; i < 128; i++)
        sp_mem[i] = {sp_init(4*i+3), sp_init(4*i+2), sp_init(4*i+1), sp_init(4*i)};
    end else begin
      if (pg_re_o) pg_rdata_i <= pg_peek(int'(pg_addr_o));
      if (pg_we_o) begin
        automatic int slot = -1;
        for (int i = 0; i < 32; i++) if (ov_vld[i] && ov_addr[i] == pg_addr_o) slot = i;
        for (int i = 31; i >= 0; i--) if (slot < 0 && !ov_vld[i]) slot = i;
        if (slot >= 0) begin
          ov_vld[slot] = 1'b1; ov_addr[slot] = pg_addr_o; ov_data[slot] = pg_wdata_o;
        end
      end
      if (sp_re_o) sp_rdata_i <= sp_mem[sp_addr_o];
      if (sp_we_o) sp_mem[sp_addr_o] = sp_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) st_mem[i] = '0;
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 12; w++) loc_mem[s][w] = '0;
      for (int w = 0; w < 6; w++) val_mem[s][w] = '0;
    end
    @(negedge clk_i) clr_mem = 1'b1;
    @(negedge clk_i) clr_mem = 1'b0;
  endtask

  task automatic set_stat(input int s, input logic [7:0] b);
    st_mem[s / 4][(s % 4) * 8 +: 8] = b;
  endtask

  task automatic set_err(input int s, input int e, input int loc, input logic [7:0] v);
    if (e % 2 == 0) loc_mem[s][e / 2][10:0]  = 11'(loc);
    else            loc_mem[s][e / 2][26:16] = 11'(loc);
    val_mem[s][e / 4][(e % 4) * 8 +: 8] = v;
  endtask

  function automatic logic [7:0] corr(input int n);
    return {1'b0, 5'(n), 2'b01};
  endfunction

  logic [8:0] got_cnt;
  logic       got_fail;
  int         got_done;

  task automatic run(input logic [1:0] st, input logic [1:0] ps, input int spsz);
    strength_i = st; page_size_i = ps; spare_size_i = 9'(spsz);
    got_done = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    for (int c = 0; c < 3000 && got_done == 0; c++) begin
      @(negedge clk_i);
      if (done_o) begin got_done++; got_cnt = corr_cnt_o; got_fail = fail_o; end
    end
  endtask

  task automatic t_reset();
    chk(done_o == 0 && fail_o == 0 && corr_cnt_o == 0, "R13 reset outputs", int'(corr_cnt_o), 0);
    chk(!rep_re_o && !pg_re_o && !pg_we_o && !sp_re_o && !sp_we_o, "R13 reset enables", 1, 0);
  endtask

  task automatic t_clean();
    clear_all();
    run(2'd0, 2'd0, 64);
    chk(got_done == 1, "R9 clean pass done", got_done, 1);
    chk(got_cnt == 0 && !got_fail, "R1 clean count", int'(got_cnt), 0);
    chk(pg_peek(5) == pg_init(5), "R1 clean page untouched", pg_peek(5), pg_init(5));
  endtask

  task automatic t_data();
    clear_all();
    set_stat(1, corr(3));
    set_err(1, 0, 5, 8'h01); set_err(1, 1, 511, 8'h80); set_err(1, 2, 100, 8'hFF);
    set_stat(3, corr(1)); set_err(3, 0, 0, 8'h3C);
    run(2'd0, 2'd0, 64);
    chk(pg_peek(517) == (pg_init(517) ^ 8'h01), "R4 data byte even slot", pg_peek(517), pg_init(517) ^ 8'h01);
    chk(pg_peek(1023) == (pg_init(1023) ^ 8'h80), "R3 odd location half", pg_peek(1023), pg_init(1023) ^ 8'h80);
    chk(pg_peek(612) == (pg_init(612) ^ 8'hFF), "R3 value lane 2", pg_peek(612), pg_init(612) ^ 8'hFF);
    chk(pg_peek(1536) == (pg_init(1536) ^ 8'h3C), "R1 slot 3 of word 0", pg_peek(1536), pg_init(1536) ^ 8'h3C);
    chk(got_cnt == 4 && !got_fail, "R2 summed count", int'(got_cnt), 4);
  endtask

  task automatic t_spare();
    clear_all();
    // 12-bit strength, 4 KiB: 8 sectors, 23 parity, first parity loc 521, base 224-184=40
    set_stat(2, corr(5));
    set_err(2, 0, 512, 8'h11); set_err(2, 1, 514, 8'h22); set_err(2, 2, 516, 8'h33);
    set_err(2, 3, 521, 8'h44); set_err(2, 4, 530, 8'h55);
    run(2'd1, 2'd1, 224);
    chk(sp_peek(0) == (sp_init(0) ^ 8'h11), "R5 protected byte 0", sp_peek(0), sp_init(0) ^ 8'h11);
    chk(sp_peek(2) == (sp_init(2) ^ 8'h22), "R5 protected byte 2", sp_peek(2), sp_init(2) ^ 8'h22);
    chk(sp_peek(4) == sp_init(4) && sp_peek(3) == sp_init(3), "R7 gap location skipped", sp_peek(4), sp_init(4));
    chk(sp_peek(86) == (sp_init(86) ^ 8'h44), "R6 first parity byte", sp_peek(86), sp_init(86) ^ 8'h44);
    chk(sp_peek(95) == (sp_init(95) ^ 8'h55), "R6 parity offset 9", sp_peek(95), sp_init(95) ^ 8'h55);
    chk(sp_peek(87) == sp_init(87) && sp_peek(85) == sp_init(85) && sp_peek(84) == sp_init(84),
        "R12 neighbour lanes kept", sp_peek(87), sp_init(87));
    chk(got_cnt == 5, "R7 gap still counted", int'(got_cnt), 5);
  endtask

  task automatic t_t24();
    clear_all();
    // 24-bit strength, 8 KiB: 8 sectors, 45 parity, first parity loc 1043, base 436-360=76
    set_stat(6, corr(2)); set_err(6, 0, 1043, 8'h66); set_err(6, 1, 1050, 8'h77);
    set_stat(5, corr(1)); set_err(5, 0, 1023, 8'h88);
    run(2'd2, 2'd2, 436);
    chk(sp_peek(346) == (sp_init(346) ^ 8'h66), "R8 t24 parity base", sp_peek(346), sp_init(346) ^ 8'h66);
    chk(sp_peek(353) == (sp_init(353) ^ 8'h77), "R6 t24 parity offset", sp_peek(353), sp_init(353) ^ 8'h77);
    chk(pg_peek(6143) == (pg_init(6143) ^ 8'h88), "R8 1024-byte sector", pg_peek(6143), pg_init(6143) ^ 8'h88);
    chk(got_cnt == 3, "R9 second status word", int'(got_cnt), 3);
  endtask

  task automatic t_8k512();
    clear_all();
    set_stat(15, corr(1)); set_err(15, 0, 511, 8'h5A);
    run(2'd0, 2'd3, 256);
    chk(pg_peek(8191) == (pg_init(8191) ^ 8'h5A), "R9 last of four words", pg_peek(8191), pg_init(8191) ^ 8'h5A);
    chk(got_cnt == 1, "R9 8k count", int'(got_cnt), 1);
  endtask

  task automatic t_fail();
    clear_all();
    set_stat(0, corr(1)); set_err(0, 0, 3, 8'h0F);
    set_stat(1, 8'h02);
    set_stat(2, corr(1)); set_err(2, 0, 9, 8'hF0);
    run(2'd0, 2'd0, 64);
    chk(got_fail == 1, "R10 fail flag", int'(got_fail), 1);
    chk(pg_peek(3) == (pg_init(3) ^ 8'h0F), "R10 earlier sector fixed", pg_peek(3), pg_init(3) ^ 8'h0F);
    chk(pg_peek(1033) == pg_init(1033), "R10 later sector untouched", pg_peek(1033), pg_init(1033));
  endtask

  task automatic t_small_page();
    clear_all();
    // 2 KiB with 1024-byte sectors: one word, slots 2 and 3 still decoded
    set_stat(1, corr(1)); set_err(1, 0, 7, 8'h99);
    set_stat(3, 8'h03);
    run(2'd3, 2'd0, 128);
    chk(pg_peek(1031) == (pg_init(1031) ^ 8'h99), "R8 strength 3 as t24", pg_peek(1031), pg_init(1031) ^ 8'h99);
    chk(got_fail == 1, "R9 slot 3 decoded", int'(got_fail), 1);
  endtask

  task automatic t_clamp();
    clear_all();
    set_stat(0, 8'h7D);
    for (int e = 0; e < 24; e++) set_err(0, e, e, 8'(e + 1));
    run(2'd0, 2'd0, 64);
    chk(got_cnt == 24, "R2 clamp to 24", int'(got_cnt), 24);
    chk(pg_peek(23) == (pg_init(23) ^ 8'd24), "R2 last clamped error", pg_peek(23), pg_init(23) ^ 8'd24);
    chk(pg_peek(0) == (pg_init(0) ^ 8'd1), "R3 first error", pg_peek(0), pg_init(0) ^ 8'd1);
  endtask

  task automatic t_busy();
    int extra = 0;
    clear_all();
    set_stat(0, corr(1)); set_err(0, 0, 40, 8'h01);
    strength_i = 2'd0; page_size_i = 2'd0; spare_size_i = 9'd64;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    got_done = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i);
      if (done_o) begin
        got_done++;
        got_cnt = corr_cnt_o;
        @(negedge clk_i);
        if (done_o) extra++;
      end
    end
    chk(got_done == 1, "R11 start ignored while busy", got_done, 1);
    chk(extra == 0, "R11 done single cycle", extra, 0);
    chk(pg_peek(40) == (pg_init(40) ^ 8'h01), "R11 single application", pg_peek(40), pg_init(40) ^ 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_clean();
    t_data();
    t_spare();
    t_t24();
    t_8k512();
    t_fail();
    t_small_page();
    t_clamp();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule